// File: doc/BRIEF.md
# PCI Target Transfer-Mode Controller

This block makes the per-transaction response decision for a host bridge that answers as a PCI target. When a transaction begins, it takes the bus command and the current control bits, and it also checks whether the bridge's outbound write buffer still holds data. From these it decides what the target does. It can force a retry. It can accept the transaction but disconnect together with the first data phase. It can accept it as a normal multi-phase transfer. For memory reads it can also ask the internal side for a whole cache line instead of a single word. Memory Write and Invalidate can be allowed to burst on the internal bus.

The decision is taken once, on the clock edge where `txn_start` is high. From the next cycle, retry and disconnect are held as levels until the edge where `txn_end` is seen. The cache-line fetch request and the write-burst grant are one-cycle pulses in that same first cycle. Control bits and the buffer flag are read only at the start edge, so they may change freely while a transaction is in progress. The data path and the internal bus logic sit outside this block and use its outputs.

Top module: `pci_tgt_xfer_ctl`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls (asynchronously), all four outputs are 0.
- R2: A read or write that starts with `cfg_retry_busy`=1 and `wbuf_not_empty`=1 raises `rsp_retry` from the next cycle until the edge that sees `txn_end`. A retried transaction gets no disconnect, no line fetch and no burst grant.
- R3: With `cfg_retry_busy`=0, `wbuf_not_empty` is ignored. The transaction is accepted, and disconnect, fetch and burst are decided as if the buffer were empty.
- R4: Writes are codes 0011, 0111, 1011 and 1111. A write that starts with `cfg_single_wr`=1 raises `rsp_disconnect` from the next cycle until `txn_end`. With the bit at 0, writes are never disconnected. `cfg_single_rd` has no effect on writes.
- R5: Reads are codes 0010, 0110, 1010, 1100 and 1110. A read that starts with `cfg_single_rd`=1 raises `rsp_disconnect` in the same way. With the bit at 0, reads are never disconnected. `cfg_single_wr` has no effect on reads.
- R6: With `cfg_line_rd`=1, every memory read (0110, 1100, 1110) gives a one-cycle `line_fetch_req` in the cycle after the start. I/O and configuration reads never do.
- R7: With `cfg_line_rd`=0, only 1100 and 1110 give `line_fetch_req`. 0110 is fetched as a single transfer.
- R8: `wr_burst_go` pulses for one cycle after the start only for code 1111 with `cfg_wr_burst`=1. `cfg_wr_burst` never changes the read fetch decision.
- R9: Changes of the control inputs or `wbuf_not_empty` after the start edge do not change the outputs of the transaction in progress.
- R10: Any other code (0000, 0001, 0100, 0101, 1000, 1001, 1101) produces no output at all, whatever the control bits are.
- R11: When `txn_start` and `txn_end` are high on the same edge, the new transaction's decision replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | First cycle of a target transaction; `txn_cmd` is valid |
| txn_end | input | 1 | Transaction finished; held responses drop |
| txn_cmd | input | 4 | PCI bus command code |
| cfg_single_wr | input | 1 | Disconnect writes with the first data phase |
| cfg_single_rd | input | 1 | Disconnect reads with the first data phase |
| cfg_retry_busy | input | 1 | Retry while the outbound write buffer holds data |
| cfg_line_rd | input | 1 | Fetch a full cache line for every memory read |
| cfg_wr_burst | input | 1 | Allow internal burst for Memory Write and Invalidate |
| wbuf_not_empty | input | 1 | Outbound write buffer holds data |
| rsp_retry | output | 1 | Target retry for the current transaction |
| rsp_disconnect | output | 1 | Disconnect with the first data phase |
| line_fetch_req | output | 1 | One-cycle request for a cache-line read |
| wr_burst_go | output | 1 | One-cycle grant for an internal write burst |

## Verification
The hardest situation to create from the ports is a control bit or the buffer flag changing while a decision is being held. If the latch were missing, a correct-looking start would still show correct outputs. So after every table transaction the bench inverts every control input and the buffer flag in the cycle after the start, and checks the held levels again before it ends the transaction. A second hard case is an end and a new start on the same edge. Directed back-to-back sequences cover it, with the new decision either dropping or replacing the old one.

// File: rtl/pci_xfer_pkg.sv
package pci_xfer_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [CMD_W-1:0] CMD_MEM_WR_INV  = 4'b1111;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_READ  = 2'd1,
    CLS_WRITE = 2'd2
  } cmd_class_e;

  typedef struct packed {
    logic single_wr;
    logic single_rd;
    logic retry_busy;
    logic line_rd;
    logic wr_burst;
  } xfer_mode_t;

  typedef struct packed {
    logic retry;
    logic disc;
    logic line;
    logic burst;
  } xfer_verdict_t;

  // Reads: I/O, memory, config, memory read multiple, memory read line.
  // Writes: I/O, memory, config, memory write and invalidate.
  function automatic cmd_class_e classify(input logic [CMD_W-1:0] c);
    case (c)
      4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110: classify = CLS_READ;
      4'b0011, 4'b0111, 4'b1011, 4'b1111:          classify = CLS_WRITE;
      default:                                     classify = CLS_NONE;
    endcase
  endfunction

  function automatic logic is_mem_read(input logic [CMD_W-1:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
  endfunction

  function automatic logic wants_line(input logic [CMD_W-1:0] c);
    return (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
  endfunction

endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_xfer_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_class_e       cls,
  output logic             mem_rd,
  output logic             line_cmd,
  output logic             mwi_cmd
);

  always_comb begin
    cls      = classify(cmd);
    mem_rd   = is_mem_read(cmd);
    line_cmd = wants_line(cmd);
    mwi_cmd  = (cmd == CMD_MEM_WR_INV);
  end

endmodule

// File: rtl/pci_xfer_policy.sv
module pci_xfer_policy
  import pci_xfer_pkg::*;
(
  input  cmd_class_e    cls,
  input  logic          mem_rd,
  input  logic          line_cmd,
  input  logic          mwi_cmd,
  input  xfer_mode_t    mode,
  input  logic          wbuf_ne,
  output xfer_verdict_t verdict
);

  logic is_txn;
  logic do_retry;

  always_comb begin
    is_txn   = (cls != CLS_NONE);
    // retry outranks every other response
    do_retry = is_txn && mode.retry_busy && wbuf_ne;

    verdict.retry = do_retry;
    verdict.disc  = !do_retry &&
                    (((cls == CLS_WRITE) && mode.single_wr) ||
                     ((cls == CLS_READ)  && mode.single_rd));
    verdict.line  = !do_retry && mem_rd && (mode.line_rd || line_cmd);
    verdict.burst = !do_retry && mwi_cmd && mode.wr_burst;
  end

endmodule

// File: rtl/pci_xfer_track.sv
module pci_xfer_track
  import pci_xfer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  input  xfer_verdict_t verdict,
  output logic          retry_q,
  output logic          disc_q,
  output logic          line_q,
  output logic          burst_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q <= 1'b0;
      disc_q  <= 1'b0;
      line_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      line_q  <= start && verdict.line;
      burst_q <= start && verdict.burst;
      if (start) begin
        retry_q <= verdict.retry;
        disc_q  <= verdict.disc;
      end else if (done) begin
        retry_q <= 1'b0;
        disc_q  <= 1'b0;
      end
    end
  end

  assert_retry_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && verdict.retry |=> retry_q && !disc_q);

  assert_end_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !retry_q && !disc_q);

  assert_held_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !done |=> $stable(retry_q) && $stable(disc_q));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !line_q && !burst_q);

endmodule

// File: rtl/pci_tgt_xfer_ctl.sv
module pci_tgt_xfer_ctl
  import pci_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             txn_end,
  input  logic [CMD_W-1:0] txn_cmd,
  input  logic             cfg_single_wr,
  input  logic             cfg_single_rd,
  input  logic             cfg_retry_busy,
  input  logic             cfg_line_rd,
  input  logic             cfg_wr_burst,
  input  logic             wbuf_not_empty,
  output logic             rsp_retry,
  output logic             rsp_disconnect,
  output logic             line_fetch_req,
  output logic             wr_burst_go
);

  cmd_class_e    dec_cls;
  logic          dec_mem_rd;
  logic          dec_line_cmd;
  logic          dec_mwi;
  xfer_mode_t    mode_now;
  xfer_verdict_t verdict_now;

  always_comb begin
    mode_now.single_wr  = cfg_single_wr;
    mode_now.single_rd  = cfg_single_rd;
    mode_now.retry_busy = cfg_retry_busy;
    mode_now.line_rd    = cfg_line_rd;
    mode_now.wr_burst   = cfg_wr_burst;
  end

  pci_cmd_decode u_decode (
    .cmd      (txn_cmd),
    .cls      (dec_cls),
    .mem_rd   (dec_mem_rd),
    .line_cmd (dec_line_cmd),
    .mwi_cmd  (dec_mwi)
  );

  pci_xfer_policy u_policy (
    .cls      (dec_cls),
    .mem_rd   (dec_mem_rd),
    .line_cmd (dec_line_cmd),
    .mwi_cmd  (dec_mwi),
    .mode     (mode_now),
    .wbuf_ne  (wbuf_not_empty),
    .verdict  (verdict_now)
  );

  pci_xfer_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (txn_start),
    .done    (txn_end),
    .verdict (verdict_now),
    .retry_q (rsp_retry),
    .disc_q  (rsp_disconnect),
    .line_q  (line_fetch_req),
    .burst_q (wr_burst_go)
  );

  assert_no_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start && !cfg_retry_busy |=> !rsp_retry);

  assert_retry_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> !rsp_disconnect && !line_fetch_req && !wr_burst_go);

  assert_burst_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_burst_go |-> $past(txn_start) && ($past(txn_cmd) == CMD_MEM_WR_INV)
                    && $past(cfg_wr_burst));

  assert_line_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_fetch_req |-> $past(txn_start) &&
      ($past(txn_cmd) == CMD_MEM_RD_MULT || $past(txn_cmd) == CMD_MEM_RD_LINE ||
       ($past(cfg_line_rd) && $past(txn_cmd) == CMD_MEM_RD)));

  assert_other_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start && (classify(txn_cmd) == CLS_NONE) |=>
      !rsp_retry && !rsp_disconnect && !line_fetch_req && !wr_burst_go);

endmodule

// File: tb/pci_tgt_xfer_ctl_bench.sv
`timescale 1ns/1ps
module pci_tgt_xfer_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txn_start = 1'b0;
  logic       txn_end = 1'b0;
  logic [3:0] txn_cmd = 4'h0;
  logic       sw = 1'b0, sr = 1'b0, rb = 1'b0, cl = 1'b0, xb = 1'b0, wbne = 1'b0;
  logic       rsp_retry, rsp_disconnect, line_fetch_req, wr_burst_go;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pci_tgt_xfer_ctl u_pci_tgt_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
    .txn_cmd(txn_cmd), .cfg_single_wr(sw), .cfg_single_rd(sr),
    .cfg_retry_busy(rb), .cfg_line_rd(cl), .cfg_wr_burst(xb),
    .wbuf_not_empty(wbne), .rsp_retry(rsp_retry),
    .rsp_disconnect(rsp_disconnect), .line_fetch_req(line_fetch_req),
    .wr_burst_go(wr_burst_go)
  );

  // outputs packed as {retry, disconnect, line, burst}
  function automatic logic [3:0] outs();
    return {rsp_retry, rsp_disconnect, line_fetch_req, wr_burst_go};
  endfunction

  task automatic chk(input logic [3:0] exp, input int tag, input string what);
    logic [3:0] got;
    got = outs();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s got=%b exp=%b", tag, what, got, exp);
    end
  endtask

  // {cmd, sw, sr, rb, cl, xb, wbne, exp{retry,disc,line,burst}, tag}
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {4'h7, 6'b000000, 4'b0000, 4'd4},  // R4 multi-phase write accepted
    {4'h7, 6'b100000, 4'b0100, 4'd4},  // R4 single write
    {4'h3, 6'b100000, 4'b0100, 4'd4},  // R4 I/O write
    {4'h6, 6'b100000, 4'b0000, 4'd5},  // R5 single-write bit ignored on read
    {4'h6, 6'b010000, 4'b0100, 4'd5},  // R5 single read
    {4'hA, 6'b010000, 4'b0100, 4'd5},  // R5 config read
    {4'h6, 6'b001001, 4'b1000, 4'd2},  // R2 retry
    {4'h7, 6'b101111, 4'b1000, 4'd2},  // R2 retry beats disconnect
    {4'hC, 6'b011101, 4'b1000, 4'd2},  // R2 retry beats fetch
    {4'h7, 6'b100001, 4'b0100, 4'd3},  // R3 buffer flag ignored
    {4'hE, 6'b000001, 4'b0010, 4'd3},  // R3 fetch despite busy buffer
    {4'h6, 6'b000100, 4'b0010, 4'd6},  // R6 line enable, memory read
    {4'h2, 6'b000100, 4'b0000, 4'd6},  // R6 I/O read no fetch
    {4'h6, 6'b000000, 4'b0000, 4'd7},  // R7 single transfer
    {4'hC, 6'b000000, 4'b0010, 4'd7},  // R7 read multiple
    {4'hE, 6'b010000, 4'b0110, 4'd7},  // R7 read line + single read
    {4'hF, 6'b000010, 4'b0001, 4'd8},  // R8 MWI burst
    {4'hF, 6'b000000, 4'b0000, 4'd8},  // R8 MWI no burst
    {4'h7, 6'b000010, 4'b0000, 4'd8},  // R8 plain write never bursts
    {4'h6, 6'b000010, 4'b0000, 4'd8},  // R8 burst bit leaves reads single
    {4'hF, 6'b100010, 4'b0101, 4'd4},  // R4 MWI single write
    {4'h0, 6'b111111, 4'b0000, 4'd10}, // R10
    {4'hD, 6'b111111, 4'b0000, 4'd10}, // R10
    {4'h1, 6'b111110, 4'b0000, 4'd10}  // R10
  };

  task automatic drive(input logic [3:0] c, input logic [5:0] m);
    txn_cmd = c;
    {sw, sr, rb, cl, xb, wbne} = m;
  endtask

  initial begin : watchdog
    while (cycles < 100000) @(posedge clk) cycles++;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 chk(4'b0000, 1, "outputs in reset");   // R1
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk(4'b0000, 1, "after reset release"); // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][17:14], VEC[i][13:8]);
      txn_start = 1'b1;
      @(posedge clk); #1 chk(VEC[i][7:4], int'(VEC[i][3:0]), $sformatf("vec %0d first cycle", i));
      @(negedge clk);
      txn_start = 1'b0;
      // R9: invert every control input mid-transaction
      {sw, sr, rb, cl, xb, wbne} = ~VEC[i][13:8];
      @(posedge clk); #1 chk({VEC[i][7:6], 2'b00}, 9, $sformatf("vec %0d held", i));
      @(negedge clk) txn_end = 1'b1;
      @(posedge clk); #1 chk(4'b0000, 2, $sformatf("vec %0d cleared by end", i));
      @(negedge clk) txn_end = 1'b0;
    end

    // R11: end and new start on one edge, new decision drops disconnect
    @(negedge clk); drive(4'h7, 6'b100000); txn_start = 1'b1;
    @(posedge clk); #1 chk(4'b0100, 11, "b2b first write");
    @(negedge clk); drive(4'h6, 6'b100000); txn_end = 1'b1;
    @(posedge clk); #1 chk(4'b0000, 11, "b2b read replaces");
    // R11: replaced by a retry
    @(negedge clk); drive(4'h7, 6'b001001);
    @(posedge clk); #1 chk(4'b1000, 11, "b2b retry replaces");
    @(negedge clk); txn_start = 1'b0;
    @(posedge clk); #1 chk(4'b0000, 11, "b2b final end");
    @(negedge clk); txn_end = 1'b0;

    // R1: asynchronous reset while a disconnect is held
    @(negedge clk); drive(4'h7, 6'b100000); txn_start = 1'b1;
    @(posedge clk); #1 chk(4'b0100, 4, "pre-reset write");
    @(negedge clk); txn_start = 1'b0; rst_n = 1'b0;
    #1 chk(4'b0000, 1, "async reset clears");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk(4'b0000, 1, "idle after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule